// File: doc/BRIEF.md
# Four-Lane Integer Vector ALU

This block is the integer execution stage of a small vector datapath. Every operand is a 128-bit vector that holds four independent 32-bit lanes. Lane k sits at bits 32k+31 down to 32k, so lane 0 (the "x" component) occupies bits 31:0. Each accepted request produces one registered result vector.

A request is a single cycle with `in_valid` high. It carries a 5-bit operation code and up to three source vectors, called A, B and C. One clock edge later, `out_valid` is high and `out_data` holds the result. Most operations pair the lanes of the sources one to one. The three shift operations are the exception: they take a single shift amount from lane 0 of B and apply it to all four lanes of A.

The supported operations are wrapping add, multiply and multiply-add, the bitwise operations, signed and unsigned minimum and maximum, three kinds of shift, a per-lane select and absolute value. Codes that name no operation produce an all-zero result.

Top module: `ialu4`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises if no request was made, `out_valid` is 0 and `out_data` is 0.
- R2: A request sampled with `in_valid` high at a clock edge gives `out_valid` high after that edge. With `in_valid` low, `out_valid` goes low and `out_data` keeps its previous value.
- R3: Code 0 returns A+B, code 1 returns A*B and code 2 returns A*B+C, per lane. Only the low 32 bits of each product and each sum are kept. The result is identical whether the lanes are read as signed or unsigned.
- R4: Code 3 returns the bitwise inverse of A. Codes 4, 5 and 6 return A AND B, A OR B and A XOR B respectively.
- R5: Code 7 returns the smaller and code 8 the larger of A and B per lane, comparing the lanes as two's-complement signed numbers.
- R6: Code 9 returns the smaller and code 10 the larger of A and B per lane, comparing the lanes as unsigned numbers.
- R7: Codes 11 (shift left), 12 (arithmetic shift right) and 13 (logical shift right) shift every lane of A by B[4:0]. All other bits of B have no effect, so shift amounts wrap modulo 32.
- R8: The arithmetic right shift fills vacated bits with the lane's sign bit. The logical right shift and the left shift fill them with zeros.
- R9: Code 14 returns the B lane where the A lane is nonzero (any of its 32 bits set), and the C lane where the A lane is zero.
- R10: Code 15 returns the magnitude of each A lane read as signed. The lane 0x80000000 returns 0x80000000.
- R11: Codes 16 to 31 return an all-zero vector, with `out_valid` still high.
- R12: Lanes are independent. A carry, borrow or shifted-out bit in one lane never changes another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 5 | Operation code |
| src_a | input | 128 | Source vector A, four 32-bit lanes |
| src_b | input | 128 | Source vector B; B[4:0] is the shift amount |
| src_c | input | 128 | Source vector C (addend, select alternative) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 128 | Result vector |

## Verification
The only state in the block is the output register, so a fault shows at the ports on the edge after the request that exposes it. A broken lane mux or operation unit corrupts the one lane it serves. A wrong shift-amount source shows up as a difference in lanes 1 to 3 whenever B's upper lanes differ from lane 0. A fault in the hold path shows as `out_data` changing during an idle cycle. Operand values are chosen so that the signed and unsigned readings of a lane disagree, and so that carries reach lane boundaries, which makes a mix-up visible in a single request.

// File: rtl/ialu4_pkg.sv
package ialu4_pkg;

    localparam int ALU_LANES = 4;
    localparam int ALU_W     = 32;
    localparam int ALU_OPW   = 5;

    typedef enum logic [ALU_OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_MUL  = 5'd1,
        OP_MAD  = 5'd2,
        OP_NOT  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_SMIN = 5'd7,
        OP_SMAX = 5'd8,
        OP_UMIN = 5'd9,
        OP_UMAX = 5'd10,
        OP_SHL  = 5'd11,
        OP_SRA  = 5'd12,
        OP_SRL  = 5'd13,
        OP_SEL  = 5'd14,
        OP_ABS  = 5'd15
    } alu_op_e;

    // Which functional unit of a lane produces the result
    typedef enum logic [1:0] {
        GRP_ARITH = 2'd0,
        GRP_LOGIC = 2'd1,
        GRP_SHIFT = 2'd2,
        GRP_NONE  = 2'd3
    } alu_grp_e;

    function automatic alu_grp_e op_group(input logic [ALU_OPW-1:0] code);
        alu_grp_e g;
        case (code)
            OP_ADD, OP_MUL, OP_MAD, OP_SMIN, OP_SMAX,
            OP_UMIN, OP_UMAX, OP_ABS:           g = GRP_ARITH;
            OP_NOT, OP_AND, OP_OR, OP_XOR,
            OP_SEL:                             g = GRP_LOGIC;
            OP_SHL, OP_SRA, OP_SRL:             g = GRP_SHIFT;
            default:                            g = GRP_NONE;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/ialu4_arith.sv
module ialu4_arith
    import ialu4_pkg::*;
#(
    parameter int W   = ALU_W,
    parameter int OPW = ALU_OPW
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    output logic [W-1:0]   y
);

    logic [W-1:0] prod;
    logic [W-1:0] sum_ab;
    logic [W-1:0] sum_pc;
    logic [W-1:0] neg_a;
    logic         s_lt;
    logic         u_lt;

    // Products and sums truncated to the lane width
    assign prod   = a * b;
    assign sum_ab = a + b;
    assign sum_pc = prod + c;
    assign neg_a  = (~a) + {{(W-1){1'b0}}, 1'b1};
    assign s_lt   = $signed(a) < $signed(b);
    assign u_lt   = a < b;

    always_comb begin
        case (op)
            OP_ADD:  y = sum_ab;
            OP_MUL:  y = prod;
            OP_MAD:  y = sum_pc;
            OP_SMIN: y = s_lt ? a : b;
            OP_SMAX: y = s_lt ? b : a;
            OP_UMIN: y = u_lt ? a : b;
            OP_UMAX: y = u_lt ? b : a;
            OP_ABS:  y = a[W-1] ? neg_a : a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/ialu4_logic.sv
module ialu4_logic
    import ialu4_pkg::*;
#(
    parameter int W   = ALU_W,
    parameter int OPW = ALU_OPW
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    output logic [W-1:0]   y
);

    logic a_nz;

    assign a_nz = |a;

    always_comb begin
        case (op)
            OP_NOT:  y = ~a;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SEL:  y = a_nz ? b : c;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/ialu4_shift.sv
module ialu4_shift
    import ialu4_pkg::*;
#(
    parameter int W   = ALU_W,
    parameter int OPW = ALU_OPW,
    parameter int SHW = $clog2(W)
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   y
);

    logic [W-1:0] left;
    logic [W-1:0] right_log;
    logic [W-1:0] right_ari;

    assign left      = a << amt;
    assign right_log = a >> amt;
    assign right_ari = W'($signed(a) >>> amt);

    always_comb begin
        case (op)
            OP_SHL:  y = left;
            OP_SRA:  y = right_ari;
            OP_SRL:  y = right_log;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/ialu4_lane.sv
module ialu4_lane
    import ialu4_pkg::*;
#(
    parameter int W   = ALU_W,
    parameter int OPW = ALU_OPW,
    parameter int SHW = $clog2(W)
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   y
);

    logic [W-1:0] y_arith;
    logic [W-1:0] y_logic;
    logic [W-1:0] y_shift;
    alu_grp_e     grp;

    ialu4_arith #(.W(W), .OPW(OPW)) u_arith (
        .op (op), .a (a), .b (b), .c (c), .y (y_arith)
    );

    ialu4_logic #(.W(W), .OPW(OPW)) u_logic (
        .op (op), .a (a), .b (b), .c (c), .y (y_logic)
    );

    ialu4_shift #(.W(W), .OPW(OPW), .SHW(SHW)) u_shift (
        .op (op), .a (a), .amt (amt), .y (y_shift)
    );

    assign grp = op_group(op);

    always_comb begin
        case (grp)
            GRP_ARITH: y = y_arith;
            GRP_LOGIC: y = y_logic;
            GRP_SHIFT: y = y_shift;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/ialu4.sv
module ialu4
    import ialu4_pkg::*;
#(
    parameter int LANES = ALU_LANES,
    parameter int W     = ALU_W,
    parameter int OPW   = ALU_OPW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OPW-1:0]     op,
    input  logic [LANES*W-1:0] src_a,
    input  logic [LANES*W-1:0] src_b,
    input  logic [LANES*W-1:0] src_c,
    output logic               out_valid,
    output logic [LANES*W-1:0] out_data
);

    localparam int VW  = LANES * W;
    localparam int SHW = $clog2(W);

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] dat;
    } stage_t;

    stage_t        st_d;
    stage_t        st_q;
    logic [VW-1:0] lane_res;
    logic [SHW-1:0] shamt;

    // Shift amount comes from lane 0 of B only, broadcast to all lanes
    assign shamt = src_b[SHW-1:0];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ialu4_lane #(.W(W), .OPW(OPW), .SHW(SHW)) u_lane (
            .op  (op),
            .a   (src_a[k*W +: W]),
            .b   (src_b[k*W +: W]),
            .c   (src_c[k*W +: W]),
            .amt (shamt),
            .y   (lane_res[k*W +: W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.dat = lane_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

endmodule

// File: rtl/ialu4_chk.sv
module ialu4_chk #(
    parameter int LANES = 4,
    parameter int W     = 32,
    parameter int OPW   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [OPW-1:0]     op,
    input logic [LANES*W-1:0] src_a,
    input logic [LANES*W-1:0] src_b,
    input logic [LANES*W-1:0] src_c,
    input logic               out_valid,
    input logic [LANES*W-1:0] out_data
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(out_data));

    // R3
    add_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd0) |=>
            out_data[W-1:0] == W'($past(src_a[W-1:0]) + $past(src_b[W-1:0])));

    // R4
    not_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd3) |=> out_data == ~$past(src_a));

    // R7
    shl_top_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd11) |=>
            out_data[LANES*W-1 -: W] ==
            W'($past(src_a[LANES*W-1 -: W]) << $past(src_b[4:0])));

    // R9
    sel_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd14) |=>
            out_data[2*W-1 -: W] ==
            (($past(src_a[2*W-1 -: W]) != '0) ? $past(src_b[2*W-1 -: W])
                                              : $past(src_c[2*W-1 -: W])));

    // R11
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[OPW-1]) |=> out_data == '0);

endmodule

bind ialu4 ialu4_chk #(.LANES(LANES), .W(W), .OPW(OPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src_a     (src_a),
    .src_b     (src_b),
    .src_c     (src_c),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/ialu4_tb.sv
`timescale 1ns/1ps
module ialu4_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [4:0]   op = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] src_c = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ialu4 u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op (op),
        .src_a (src_a), .src_b (src_b), .src_c (src_c),
        .out_valid (out_valid), .out_data (out_data)
    );

    // Reference for one lane, written from the requirements
    function automatic logic [31:0] model(input logic [4:0] code, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] c,
                                          input logic [4:0] s);
        logic [63:0] full;
        case (code)
            5'd0:  return a + b;
            5'd1:  begin full = {32'd0, a} * {32'd0, b}; return full[31:0]; end
            5'd2:  begin full = {32'd0, a} * {32'd0, b}; return full[31:0] + c; end
            5'd3:  return ~a;
            5'd4:  return a & b;
            5'd5:  return a | b;
            5'd6:  return a ^ b;
            5'd7:  return ($signed(a) <= $signed(b)) ? a : b;
            5'd8:  return ($signed(a) >= $signed(b)) ? a : b;
            5'd9:  return (a <= b) ? a : b;
            5'd10: return (a >= b) ? a : b;
            5'd11: return a << s;
            5'd12: begin full = {{32{a[31]}}, a} >> s; return full[31:0]; end
            5'd13: return a >> s;
            5'd14: return (a != 32'd0) ? b : c;
            5'd15: return a[31] ? (32'd0 - a) : a;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request and check the result one edge later
    task automatic run_op(input string req, input logic [4:0] code, input logic [127:0] a,
                          input logic [127:0] b, input logic [127:0] c);
        logic [127:0] exp;
        for (int k = 0; k < 4; k++)
            exp[k*32 +: 32] = model(code, a[k*32 +: 32], b[k*32 +: 32], c[k*32 +: 32], b[4:0]);
        @(negedge clk);
        in_valid = 1'b1; op = code; src_a = a; src_b = b; src_c = c;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {127'd0, out_valid}, 128'd1);
        check(req, out_data, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {127'd0, out_valid}, 128'd0);
        check("R1", out_data, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {127'd0, out_valid}, 128'd0);
        check("R1", out_data, 128'd0);
    endtask

    task automatic t_arith;
        // R3 and R12: carries at lane edges, negative products
        run_op("R3", 5'd0, {32'h7FFFFFFF, 32'h00000001, 32'h12345678, 32'hFFFFFFFF},
                           {32'h00000001, 32'hFFFFFFFF, 32'h11111111, 32'h00000001}, '0);
        run_op("R3", 5'd1, {32'hFFFFFFFF, 32'h00010000, 32'h0000FFFF, 32'd7},
                           {32'hFFFFFFFD, 32'h00010000, 32'h0000FFFF, 32'd6}, '0);
        run_op("R3", 5'd2, {32'h80000000, 32'hFFFFFFFF, 32'd3, 32'd5},
                           {32'd2, 32'hFFFFFFFF, 32'd4, 32'd9},
                           {32'd1, 32'hFFFFFFFF, 32'hFFFFFFF4, 32'd100});
    endtask

    task automatic t_logic;
        logic [127:0] a = 128'hF0F0F0F0_00000000_FFFFFFFF_A5A55A5A;
        logic [127:0] b = 128'h0FF00FF0_12345678_00000000_FFFF0000;
        run_op("R4", 5'd3, a, b, '0);
        run_op("R4", 5'd4, a, b, '0);
        run_op("R4", 5'd5, a, b, '0);
        run_op("R4", 5'd6, a, b, '0);
    endtask

    task automatic t_minmax;
        logic [127:0] a = {32'hFFFFFFFF, 32'h80000000, 32'd5, 32'h7FFFFFFF};
        logic [127:0] b = {32'd1, 32'h7FFFFFFF, 32'd5, 32'h80000001};
        run_op("R5", 5'd7, a, b, '0);
        run_op("R5", 5'd8, a, b, '0);
        run_op("R6", 5'd9, a, b, '0);
        run_op("R6", 5'd10, a, b, '0);
    endtask

    task automatic t_shift;
        logic [127:0] a = {32'h80000001, 32'hF0000000, 32'h7FFFFFFF, 32'h0000C0DE};
        // R7: lane 0 of B holds 0x25 -> amount 5; upper lanes carry decoys
        logic [127:0] b = {32'd1, 32'd2, 32'd3, 32'hFFFFFF25};
        run_op("R7", 5'd11, a, b, '0);
        run_op("R8", 5'd12, a, b, '0);
        run_op("R8", 5'd13, a, b, '0);
        run_op("R7", 5'd12, a, {96'd0, 32'h0000001F}, '0);
        run_op("R7", 5'd11, a, {96'd7, 32'h00000020}, '0);
    endtask

    task automatic t_sel_abs;
        run_op("R9", 5'd14, {32'h80000000, 32'd0, 32'd1, 32'd0},
                            {32'hAAAA0001, 32'hAAAA0002, 32'hAAAA0003, 32'hAAAA0004},
                            {32'h55550001, 32'h55550002, 32'h55550003, 32'h55550004});
        run_op("R10", 5'd15, {32'h80000000, 32'hFFFFFFFF, 32'd0, 32'h7FFFFFFF}, '0, '0);
        run_op("R10", 5'd15, {32'h80000001, 32'hFFFFFF00, 32'd42, 32'h00000001}, '0, '0);
    endtask

    task automatic t_undef;
        run_op("R11", 5'd20, {4{32'hDEADBEEF}}, {4{32'h12345678}}, {4{32'h1}});
        run_op("R11", 5'd31, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, '0);
    endtask

    task automatic t_hold;
        logic [127:0] held;
        run_op("R2", 5'd0, {4{32'd10}}, {4{32'd20}}, '0);
        held = out_data;
        @(negedge clk);
        op = 5'd3; src_a = {4{32'h0F0F0F0F}};
        @(negedge clk);
        check("R2", {127'd0, out_valid}, 128'd0);
        check("R2", out_data, held);
        // back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; op = 5'd5; src_a = {4{32'h00FF0000}}; src_b = {4{32'h000000FF}};
        @(negedge clk);
        check("R2", out_data, {4{32'h00FF00FF}});
        op = 5'd4;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {127'd0, out_valid}, 128'd1);
        check("R2", out_data, 128'd0);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_minmax();
        t_shift();
        t_sel_abs();
        t_undef();
        t_hold();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule